// File: doc/BRIEF.md
# Block-Based Branch Target Buffer

This block predicts where instruction fetch goes next. Fetch works on aligned 16-byte blocks, and the buffer answers before any byte of the block has been decoded. It does not ask which instruction is a branch. It asks which recorded branch ends inside the block at or after the point where fetch enters it. Each entry describes one branch by the position of the branch's last byte within its block. The ways of a set may hold up to four different branches of the same block, so the whole block can be predicted in one lookup.

Lookups arrive on a valid/ready request channel carrying the fetch address. One cycle after a request is accepted, a response appears on a valid/ready channel. The response carries a hit flag, the next fetch address and the in-block offset of the chosen branch. The response is held unchanged while `rsp_ready` is low. While a response is waiting, no new request is accepted. When the response predicts a taken branch, `lk_ready` is low for the cycle in which that response is shown, so the target block is fetched one cycle later than a sequential block would be. Resolved branches are reported on a plain update port that is accepted on every cycle in which `upd_valid` is high. Each update carries the branch's last-byte address, its target and a taken bit.

Top module: `btb_block_predictor`

## Requirements
- R1: After reset every entry is invalid. `rsp_valid` is 0 and `lk_ready` is 1, and the first lookup misses.
- R2: An address is split into three fields. Bits [3:0] are the offset in the block, bits [10:4] select one of 128 sets, and bits [31:11] form the tag. A lookup matches an entry only when both the set and the tag are equal, so an address with the same set and a different tag misses.
- R3: Each accepted lookup produces exactly one response in the following cycle. On a miss the response has hit=0, offset 0, and next address equal to the fetch address with bits [3:0] cleared plus 16.
- R4: On a hit, the buffer considers the valid, tag-matching, taken entries whose offset is greater than or equal to the fetch offset. It picks the one with the smallest offset, reports that offset and returns its target as the next address.
- R5: Entries whose offset is below the fetch offset, and entries stored with taken=0, never produce a hit.
- R6: One set holds four branches of the same block at once, and each can be selected by choosing the fetch offset.
- R7: An update whose tag, set and offset match a valid entry rewrites that entry's target and taken bit in place, and no other entry of the set is lost.
- R8: A new branch goes into the lowest-numbered invalid way. When the set is full, a 3-node tree pseudo-LRU picks the victim. Each update and each lookup hit turns every node on the accessed way's path to point away from it, and the victim is found by following the pointers from the root (0 = lower half). For example, if ways 0 to 3 are filled in order and way 0 is then hit, the next allocation replaces way 2.
- R9: When `upd_valid` and `lk_valid` address the same set in one cycle, `lk_ready` is 0. The update is written, and the lookup, presented again in the next cycle, sees the new contents. An update to a different set does not stall a lookup.
- R10: While a taken-hit response is shown, `lk_ready` is 0. This costs exactly one fetch cycle. Miss responses allow a new request to be accepted in the same cycle.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay stable and `lk_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle when high with `lk_valid` |
| lk_addr | input | 32 | Fetch address; bits [3:0] are the entry offset in the block |
| rsp_valid | output | 1 | Prediction response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | A taken branch was found in the block |
| rsp_next_addr | output | 32 | Predicted next fetch address |
| rsp_offset | output | 4 | Last-byte offset of the chosen branch, 0 on a miss |
| upd_valid | input | 1 | Resolved-branch update valid |
| upd_addr | input | 32 | Address of the branch's last byte |
| upd_target | input | 32 | Branch target address |
| upd_taken | input | 1 | Direction to store for this branch |

## Verification
The assertions assume that the update source never reports two branches with the same tag, set and offset as separate entries. That condition is the premise of the single-match and single-selection checks. They also assume that `rsp_ready` is a plain input that the consumer may hold low for any length of time. The bench drives every input half a cycle away from the sampling edge. Each branch in its stimulus is unique per block. The bench exercises the same-set collision and a stalled consumer only through the ports, so every input sequence stays inside what the assertions assume.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int ADDR_W    = 32;
  localparam int BLK_BYTES = 16;
  localparam int SETS      = 128;
  localparam int OFF_W     = $clog2(BLK_BYTES);
  localparam int IDX_W     = $clog2(SETS);
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W     = ADDR_W - OFF_W;

  typedef logic [IDX_W-1:0]  set_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // one stored branch; presence is kept in a separate reset vector
  typedef struct packed {
    logic  taken;
    tag_t  tag;
    off_t  off;
    addr_t target;
  } entry_t;
endpackage

// File: rtl/btb_way_bank.sv
module btb_way_bank
  import btb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  set_t   wr_set,
  input  entry_t wr_data,
  input  set_t   rd_set_a,
  output logic   rd_valid_a,
  output entry_t rd_data_a,
  input  set_t   rd_set_b,
  output logic   rd_valid_b,
  output entry_t rd_data_b
);
  logic [SETS-1:0] present_q;
  entry_t          store_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= '0;
    else if (wr_en) present_q[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_set] <= wr_data;
  end

  assign rd_valid_a = present_q[rd_set_a];
  assign rd_data_a  = store_q[rd_set_a];
  assign rd_valid_b = present_q[rd_set_b];
  assign rd_data_b  = store_q[rd_set_b];
endmodule

// File: rtl/btb_plru.sv
module btb_plru
  import btb_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  set_t                     rd_set,
  output logic [$clog2(WAYS)-1:0]  victim,
  input  logic                     ta_en,
  input  set_t                     ta_set,
  input  logic [$clog2(WAYS)-1:0]  ta_way,
  input  logic                     tb_en,
  input  set_t                     tb_set,
  input  logic [$clog2(WAYS)-1:0]  tb_way
);
  localparam int WAY_W = $clog2(WAYS);

  // heap-ordered tree: node n has children 2n and 2n+1, node 1 is the root
  logic [WAYS-1:1] tree_q [SETS];

  function automatic logic [WAYS-1:1] touch(input logic [WAYS-1:1] s,
                                            input logic [WAY_W-1:0] w);
    logic [WAY_W:0] node;
    touch = s;
    node  = {1'b1, w};
    for (int l = 0; l < WAY_W; l++) begin
      touch[node[WAY_W:1]] = ~node[0];
      node = node >> 1;
    end
  endfunction

  function automatic logic [WAY_W-1:0] pick(input logic [WAYS-1:1] s);
    logic [WAY_W:0] node;
    node = {{WAY_W{1'b0}}, 1'b1};
    for (int l = 0; l < WAY_W; l++) begin
      node = {node[WAY_W-1:0], s[node[WAY_W-1:0]]};
    end
    pick = node[WAY_W-1:0];
  endfunction

  assign victim = pick(tree_q[rd_set]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      if (ta_en) tree_q[ta_set] <= touch(tree_q[ta_set], ta_way);
      if (tb_en && !(ta_en && ta_set == tb_set))
        tree_q[tb_set] <= touch(tree_q[tb_set], tb_way);
    end
  end

  // R9: the top stalls a lookup that shares a set with an update
  a_r9_no_dual_touch: assert property (@(posedge clk) disable iff (!rst_n)
    !(ta_en && tb_en && ta_set == tb_set));
endmodule

// File: rtl/btb_pick.sv
module btb_pick
  import btb_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WAYS-1:0]         cand,
  input  off_t                    cand_off [WAYS],
  input  off_t                    fetch_off,
  output logic                    found,
  output logic [$clog2(WAYS)-1:0] way,
  output off_t                    off
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] eligible;
  logic [WAYS-1:0] at_best;

  always_comb begin
    found = 1'b0;
    way   = '0;
    off   = '0;
    for (int w = 0; w < WAYS; w++) begin
      eligible[w] = cand[w] && (cand_off[w] >= fetch_off);
      if (eligible[w] && (!found || cand_off[w] < off)) begin
        found = 1'b1;
        way   = WAY_W'(w);
        off   = cand_off[w];
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) at_best[w] = eligible[w] && (cand_off[w] == off);
  end

  // R7: updates never duplicate a branch, so the closest branch is unique
  a_r7_unique_choice: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> $onehot(at_best));
  // R5: nothing is chosen when no candidate lies at or after the fetch offset
  a_r5_none_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible == '0) |-> !found);
endmodule

// File: rtl/btb_block_predictor.sv
module btb_block_predictor
  import btb_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_next_addr,
  output logic [OFF_W-1:0]  rsp_offset,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken
);
  localparam int WAY_W = $clog2(WAYS);

  // address fields
  set_t lk_set, upd_set;
  tag_t lk_tag, upd_tag;
  off_t lk_off, upd_off;
  assign lk_set  = lk_addr[OFF_W +: IDX_W];
  assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
  assign lk_off  = lk_addr[OFF_W-1:0];
  assign upd_set = upd_addr[OFF_W +: IDX_W];
  assign upd_tag = upd_addr[ADDR_W-1 -: TAG_W];
  assign upd_off = upd_addr[OFF_W-1:0];

  // storage, one bank per way
  logic [WAYS-1:0] rd_v_a, rd_v_b, wr_en_w;
  entry_t          rd_a [WAYS];
  entry_t          rd_b [WAYS];
  entry_t          wr_data;

  assign wr_data = '{taken: upd_taken, tag: upd_tag, off: upd_off, target: upd_target};

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    btb_way_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en_w[g]),
      .wr_set     (upd_set),
      .wr_data    (wr_data),
      .rd_set_a   (lk_set),
      .rd_valid_a (rd_v_a[g]),
      .rd_data_a  (rd_a[g]),
      .rd_set_b   (upd_set),
      .rd_valid_b (rd_v_b[g]),
      .rd_data_b  (rd_b[g])
    );
  end

  // lookup side: tag compare then closest-branch selection
  logic [WAYS-1:0]  lk_cand;
  off_t             lk_cand_off [WAYS];
  logic             pk_found;
  logic [WAY_W-1:0] pk_way;
  off_t             pk_off;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_cand[w]     = rd_v_a[w] && (rd_a[w].tag == lk_tag) && rd_a[w].taken;
      lk_cand_off[w] = rd_a[w].off;
    end
  end

  btb_pick #(.WAYS(WAYS)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand      (lk_cand),
    .cand_off  (lk_cand_off),
    .fetch_off (lk_off),
    .found     (pk_found),
    .way       (pk_way),
    .off       (pk_off)
  );

  // update side: in-place match, else first free way, else tree victim
  logic [WAYS-1:0]  upd_match;
  logic             match_any, free_any;
  logic [WAY_W-1:0] match_way, free_way, plru_victim, wr_way;

  always_comb begin
    match_any = 1'b0;
    match_way = '0;
    free_any  = 1'b0;
    free_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      upd_match[w] = rd_v_b[w] && (rd_b[w].tag == upd_tag) && (rd_b[w].off == upd_off);
      if (upd_match[w] && !match_any) begin
        match_any = 1'b1;
        match_way = WAY_W'(w);
      end
      if (!rd_v_b[w] && !free_any) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign wr_way = match_any ? match_way : (free_any ? free_way : plru_victim);

  always_comb begin
    for (int w = 0; w < WAYS; w++) wr_en_w[w] = upd_valid && (wr_way == WAY_W'(w));
  end

  // handshake
  logic rsp_valid_q, rsp_hit_q;
  addr_t rsp_next_q;
  off_t  rsp_off_q;
  logic  lk_fire;
  logic [BLK_W-1:0] seq_blk;

  assign lk_ready = !(rsp_valid_q && !rsp_ready)
                 && !(rsp_valid_q && rsp_hit_q)
                 && !(upd_valid && upd_set == lk_set);
  assign lk_fire  = lk_valid && lk_ready;
  assign seq_blk  = lk_addr[ADDR_W-1:OFF_W] + BLK_W'(1);

  btb_plru #(.WAYS(WAYS)) u_plru (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_set (upd_set),
    .victim (plru_victim),
    .ta_en  (upd_valid),
    .ta_set (upd_set),
    .ta_way (wr_way),
    .tb_en  (lk_fire && pk_found),
    .tb_set (lk_set),
    .tb_way (pk_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_next_q  <= '0;
      rsp_off_q   <= '0;
    end else if (lk_fire) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= pk_found;
      rsp_next_q  <= pk_found ? rd_a[pk_way].target : {seq_blk, {OFF_W{1'b0}}};
      rsp_off_q   <= pk_found ? pk_off : '0;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_hit       = rsp_hit_q;
  assign rsp_next_addr = rsp_next_q;
  assign rsp_offset    = rsp_off_q;

  // R3: every accepted lookup is answered in the next cycle
  a_r3_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);
  // R11: a stalled response does not move and blocks new requests
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
                                   && $stable(rsp_next_addr) && $stable(rsp_offset)));
  a_r11_block: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready);
  // R10: a taken prediction costs one fetch cycle
  a_r10_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !lk_ready);
  // R9: same-set collision holds the lookup back
  a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && lk_valid && upd_set == lk_set) |-> !lk_ready);
  // R7: a branch is never stored twice in one set
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_match));
  // R8: exactly one way is written per update
  a_r8_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $onehot(wr_en_w));
endmodule

// File: tb/btb_block_predictor_tb.sv
`timescale 1ns/1ps
module btb_block_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [31:0] rsp_next_addr;
  logic [3:0]  rsp_offset;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_addr = '0;
  logic [31:0] upd_target = '0;
  logic        upd_taken = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  btb_block_predictor dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_next_addr(rsp_next_addr), .rsp_offset(rsp_offset),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_target(upd_target),
    .upd_taken(upd_taken)
  );

  typedef struct packed {
    logic        is_upd;
    logic [31:0] addr;
    logic [31:0] tgt;
    logic        taken;
    logic        exp_hit;
    logic [31:0] exp_next;
    logic [3:0]  exp_off;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  // set 5 block 0x9050 (tag 0x12); set 9 block 0x10090 (tag 0x20)
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h9050,  32'h0,    1'b0, 1'b0, 32'h9060,  4'h0, 4'd3}, // R1 R3 cold miss
    '{1'b1, 32'h9055,  32'h4000, 1'b1, 1'b0, 32'h0,     4'h0, 4'd2},
    '{1'b0, 32'h9050,  32'h0,    1'b0, 1'b1, 32'h4000,  4'h5, 4'd4}, // R4
    '{1'b0, 32'h9056,  32'h0,    1'b0, 1'b0, 32'h9060,  4'h0, 4'd5}, // R5 below offset
    '{1'b0, 32'h9055,  32'h0,    1'b0, 1'b1, 32'h4000,  4'h5, 4'd4}, // R4 equal offset
    '{1'b1, 32'h9052,  32'h5000, 1'b0, 1'b0, 32'h0,     4'h0, 4'd5},
    '{1'b0, 32'h9050,  32'h0,    1'b0, 1'b1, 32'h4000,  4'h5, 4'd5}, // R5 not-taken skipped
    '{1'b1, 32'h905B,  32'h6000, 1'b1, 1'b0, 32'h0,     4'h0, 4'd4},
    '{1'b0, 32'h9057,  32'h0,    1'b0, 1'b1, 32'h6000,  4'hB, 4'd4}, // R4
    '{1'b0, 32'h9850,  32'h0,    1'b0, 1'b0, 32'h9860,  4'h0, 4'd2}, // R2 tag alias
    '{1'b0, 32'h9060,  32'h0,    1'b0, 1'b0, 32'h9070,  4'h0, 4'd2}, // R2 other set
    '{1'b1, 32'h9055,  32'h4400, 1'b1, 1'b0, 32'h0,     4'h0, 4'd7},
    '{1'b0, 32'h9050,  32'h0,    1'b0, 1'b1, 32'h4400,  4'h5, 4'd7}, // R7 rewrite
    '{1'b0, 32'h9056,  32'h0,    1'b0, 1'b1, 32'h6000,  4'hB, 4'd7}, // R7 neighbour kept
    '{1'b1, 32'h905E,  32'h7000, 1'b1, 1'b0, 32'h0,     4'h0, 4'd6},
    '{1'b0, 32'h905C,  32'h0,    1'b0, 1'b1, 32'h7000,  4'hE, 4'd6}, // R6
    '{1'b1, 32'h9052,  32'h5000, 1'b1, 1'b0, 32'h0,     4'h0, 4'd7},
    '{1'b0, 32'h9050,  32'h0,    1'b0, 1'b1, 32'h5000,  4'h2, 4'd6}, // R6 R7 direction flip
    '{1'b0, 32'h9053,  32'h0,    1'b0, 1'b1, 32'h4400,  4'h5, 4'd6}, // R6 four branches
    '{1'b1, 32'h10092, 32'hA000, 1'b1, 1'b0, 32'h0,     4'h0, 4'd8},
    '{1'b1, 32'h10095, 32'hB000, 1'b1, 1'b0, 32'h0,     4'h0, 4'd8},
    '{1'b1, 32'h10099, 32'hC000, 1'b1, 1'b0, 32'h0,     4'h0, 4'd8},
    '{1'b1, 32'h1009C, 32'hD000, 1'b1, 1'b0, 32'h0,     4'h0, 4'd8},
    '{1'b0, 32'h10090, 32'h0,    1'b0, 1'b1, 32'hA000,  4'h2, 4'd8}, // R8 touch way 0
    '{1'b1, 32'h1009E, 32'hE000, 1'b1, 1'b0, 32'h0,     4'h0, 4'd8},
    '{1'b0, 32'h10096, 32'h0,    1'b0, 1'b1, 32'hD000,  4'hC, 4'd8}, // R8 way 2 evicted
    '{1'b0, 32'h10090, 32'h0,    1'b0, 1'b1, 32'hA000,  4'h2, 4'd8}, // R8
    '{1'b0, 32'h10093, 32'h0,    1'b0, 1'b1, 32'hB000,  4'h5, 4'd8}, // R8
    '{1'b0, 32'h1009D, 32'h0,    1'b0, 1'b1, 32'hE000,  4'hE, 4'd8}  // R8 new entry
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_update(input logic [31:0] a, input logic [31:0] t, input logic tk);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_target = t; upd_taken = tk;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] a, output logic [37:0] res);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    #1;
    while (!lk_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    res = {rsp_valid, rsp_hit, rsp_next_addr, rsp_offset};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [37:0] res;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle state after reset
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 lk_ready", 64'(lk_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_upd) begin
        do_update(VECS[i].addr, VECS[i].tgt, VECS[i].taken);
      end else begin
        do_lookup(VECS[i].addr, res);
        chk($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(res),
            64'({1'b1, VECS[i].exp_hit, VECS[i].exp_next, VECS[i].exp_off}));
      end
    end

    // R9: same-set collision stalls the lookup, which then sees the write
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = 32'h9051; upd_target = 32'h8000; upd_taken = 1'b1;
    lk_valid = 1'b1; lk_addr = 32'h9050;
    #1;
    chk("R9 stall on same set", 64'(lk_ready), 64'd0);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    chk("R9 released", 64'(lk_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R9 sees new entry", 64'({rsp_valid, rsp_hit, rsp_next_addr, rsp_offset}),
        64'({1'b1, 1'b1, 32'h8000, 4'h1}));
    // R9: different set does not stall
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = 32'h9071; upd_target = 32'h1234; upd_taken = 1'b1;
    lk_valid = 1'b1; lk_addr = 32'h9850;
    #1;
    chk("R9 other set no stall", 64'(lk_ready), 64'd1);
    @(negedge clk);
    upd_valid = 1'b0; lk_valid = 1'b0;
    chk("R9 other set result", 64'({rsp_valid, rsp_hit, rsp_next_addr}),
        64'({1'b1, 1'b0, 32'h9860}));

    // R10: taken prediction costs one cycle, misses stream back to back
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h9050;
    @(negedge clk);
    lk_addr = 32'h8000;
    #1;
    chk("R10 taken response", 64'({rsp_valid, rsp_hit, rsp_next_addr}),
        64'({1'b1, 1'b1, 32'h8000}));
    chk("R10 bubble", 64'(lk_ready), 64'd0);
    @(negedge clk);
    #1;
    chk("R10 bubble is one cycle", 64'(lk_ready), 64'd1);
    @(negedge clk);
    lk_addr = 32'h0020;
    #1;
    chk("R10 R3 miss response", 64'({rsp_valid, rsp_hit, rsp_next_addr, rsp_offset}),
        64'({1'b1, 1'b0, 32'h8010, 4'h0}));
    chk("R10 no bubble after miss", 64'(lk_ready), 64'd1);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R10 second miss", 64'({rsp_valid, rsp_hit, rsp_next_addr}),
        64'({1'b1, 1'b0, 32'h0030}));

    // R11: back-pressure holds the response and blocks requests
    @(negedge clk);
    rsp_ready = 1'b0;
    lk_valid = 1'b1; lk_addr = 32'h10090;
    @(negedge clk);
    lk_addr = 32'h9050;
    #1;
    chk("R11 blocked", 64'(lk_ready), 64'd0);
    chk("R11 response", 64'({rsp_valid, rsp_hit, rsp_next_addr, rsp_offset}),
        64'({1'b1, 1'b1, 32'hA000, 4'h2}));
    repeat (2) @(negedge clk);
    #1;
    chk("R11 held", 64'({rsp_valid, rsp_hit, rsp_next_addr, rsp_offset}),
        64'({1'b1, 1'b1, 32'hA000, 4'h2}));
    chk("R11 still blocked", 64'(lk_ready), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    #1;
    chk("R11 consumed", 64'({rsp_valid, lk_ready}), 64'({1'b0, 1'b1}));
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R11 next request", 64'({rsp_valid, rsp_hit, rsp_next_addr, rsp_offset}),
        64'({1'b1, 1'b1, 32'h8000, 4'h1}));
    @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule